// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

This block is a free-running up-counter intended for an always-on domain, where it keeps elapsed seconds from a base time that software holds elsewhere. A slow-clock strobe feeds a programmable divider, and each divider wrap advances a 32-bit counter. Software cannot load the counter. It can only restart it, which returns both the counter and the divider to zero.

A 32-bit alarm comparator raises a flag when the counter reaches the programmed value. Every counter advance raises a second flag. The two flags share one read-to-clear status word. Each flag has its own enable, and the enabled flags combine into one level interrupt.

Software uses a small 32-bit register bus with four word registers. A read returns its data one cycle after the request. The slow clock arrives as a one-cycle strobe (`slow_tick`) that is already synchronous to `clk`. Full clock-domain crossing happens outside the block.

Top module: `tick_alarm_timer`

## Requirements
- R1: Reset values are as follows: mode reads 0x0000_8000 (the `RESET_RELOAD` parameter), alarm reads 0xFFFF_FFFF, value reads 0, status reads 0, and `irq` is low.
- R2: Mode bits [15:0] hold the divide ratio N. The counter advances by one on every Nth `slow_tick`, and N = 0 divides by 65536.
- R3: A write to mode with bit 18 set clears the counter and the divider, and counting resumes from zero. Bit 18 always reads back as 0.
- R4: The value register (offset 0x08) is read-only. A write to it leaves the counter unchanged.
- R5: Status bit 0 (alarm) sets on the advance that makes the counter equal to the alarm register (offset 0x04). It never sets while the alarm register holds all ones.
- R6: Status bit 1 (increment) sets on every counter advance.
- R7: A read of status (offset 0x0C) returns the flags and clears them. A flag event in the same cycle as the read is kept and shows in the next read.
- R8: `irq` is high exactly when some status bit n is set and mode bit 16+n is set. Bit 16 enables the alarm flag and bit 17 enables the increment flag.
- R9: The register map is mode at 0x00, alarm at 0x04, value at 0x08 and status at 0x0C. `rsp_valid` and `rsp_rdata` follow a read request by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt from the enabled status flags |

## Verification
The bench aims at the following corner cases, each with the symptom a faulty design would show:

- **Divider cleared on restart.** The bench restarts the timer partway through a divider period. A design that clears only the counter would then advance early.
- **Read-clear colliding with an increment.** The bench issues a status read in the same cycle as an increment. A design that gives the clear priority would lose the increment flag.
- **Alarm-match cycle.** The bench checks the alarm flag one advance before the match and again at the match, so a comparator that is off by one is caught.
- **Divide ratio of 0.** The bench runs a full 65536-strobe period. A design that treats 0 literally would count on every strobe or never count at all.
- **Writes that must have no effect.** The bench writes the value register and reads the restart bit back. Either one would expose a counter that can be loaded or a restart bit that sticks.

// File: rtl/tat_pkg.sv
package tat_pkg;

    localparam int DATA_W      = 32;
    localparam int PRESC_W     = 16;
    localparam int ADDR_W      = 4;
    localparam int FLAG_N      = 2;
    localparam int IE_BASE     = 16;
    localparam int RESTART_BIT = 18;

    localparam logic [DATA_W-1:0] ALARM_OFF = '1;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_ALARM  = 2'd1,
        REG_VALUE  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    // flag index 0 = alarm, 1 = increment
    localparam int FLAG_ALM = 0;
    localparam int FLAG_INC = 1;

    typedef struct packed {
        logic [FLAG_N-1:0]  ie;
        logic [PRESC_W-1:0] reload;
    } mode_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e addr_to_sel(input logic [1:0] word_idx);
        return reg_sel_e'(word_idx);
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] r;
        r = '0;
        r[PRESC_W-1:0] = m.reload;
        r[IE_BASE +: FLAG_N] = m.ie;
        return r;
    endfunction

endpackage

// File: rtl/tat_regfile.sv
module tat_regfile
    import tat_pkg::*;
#(
    parameter logic [PRESC_W-1:0] RESET_RELOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] count,
    input  logic [FLAG_N-1:0] flags,
    output mode_t             mode_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic              restart,
    output logic              status_rd,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              is_read;
    logic              is_write;
    logic [DATA_W-1:0] read_mux;

    assign is_read   = req.valid && !req.write;
    assign is_write  = req.valid &&  req.write;
    assign restart   = is_write && (req.sel == REG_MODE) && req.wdata[RESTART_BIT];
    assign status_rd = is_read && (req.sel == REG_STATUS);

    always_comb begin
        read_mux = '0;
        case (req.sel)
            REG_MODE:   read_mux = pack_mode(mode_q);
            REG_ALARM:  read_mux = alarm_q;
            REG_VALUE:  read_mux = count;
            REG_STATUS: read_mux[FLAG_N-1:0] = flags;
            default:    read_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.reload <= RESET_RELOAD;
            mode_q.ie     <= '0;
            alarm_q       <= ALARM_OFF;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
        end else begin
            rsp_valid <= is_read;
            if (is_read) begin
                rsp_rdata <= read_mux;
            end
            if (is_write) begin
                case (req.sel)
                    REG_MODE: begin
                        mode_q.reload <= req.wdata[PRESC_W-1:0];
                        mode_q.ie     <= req.wdata[IE_BASE +: FLAG_N];
                    end
                    REG_ALARM: alarm_q <= req.wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tat_prescaler.sv
module tat_prescaler
    import tat_pkg::*;
#(
    parameter int DIV_W = PRESC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    // reload 0 wraps to all ones, giving a full 2**DIV_W period
    assign last = reload - 1'b1;
    // >= lets a shrunken ratio take effect without a long wrap
    assign tick = slow_tick && !restart && (div_q >= last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (slow_tick) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tat_counter.sv
module tat_counter
    import tat_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count_q,
    output logic             inc_evt,
    output logic             alm_evt
);

    logic [CNT_W-1:0] next_count;
    logic             alarm_armed;

    assign next_count  = count_q + 1'b1;
    assign alarm_armed = (alarm != {CNT_W{1'b1}});
    assign inc_evt     = tick;
    assign alm_evt     = tick && alarm_armed && (next_count == alarm);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= next_count;
        end
    end

endmodule

// File: rtl/tat_status.sv
module tat_status
    import tat_pkg::*;
#(
    parameter int N = FLAG_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clear,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags_q,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else begin
                // a new event outranks the read-clear of the same cycle
                flags_q[i] <= evt[i] | (flags_q[i] & ~clear);
            end
        end
    end

    assign irq = |(flags_q & ie);

endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
    import tat_pkg::*;
#(
    parameter logic [PRESC_W-1:0] RESET_RELOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);

    bus_req_t          req;
    mode_t             mode_q;
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] count_q;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] evt;
    logic              restart;
    logic              status_rd;
    logic              tick;
    logic              inc_evt;
    logic              alm_evt;
    logic              addr_unused;

    // registers are word aligned; byte lane bits carry no meaning
    assign addr_unused = ^req_addr[1:0];

    assign req.valid = req_valid;
    assign req.write = req_write;
    assign req.sel   = addr_to_sel(req_addr[3:2]);
    assign req.wdata = req_wdata;

    assign evt[FLAG_ALM] = alm_evt;
    assign evt[FLAG_INC] = inc_evt;

    tat_regfile #(
        .RESET_RELOAD(RESET_RELOAD)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .count     (count_q),
        .flags     (flags_q),
        .mode_q    (mode_q),
        .alarm_q   (alarm_q),
        .restart   (restart),
        .status_rd (status_rd),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    tat_prescaler #(
        .DIV_W(PRESC_W)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .restart   (restart),
        .reload    (mode_q.reload),
        .tick      (tick)
    );

    tat_counter #(
        .CNT_W(DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .alarm   (alarm_q),
        .count_q (count_q),
        .inc_evt (inc_evt),
        .alm_evt (alm_evt)
    );

    tat_status #(
        .N(FLAG_N)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clear   (status_rd),
        .ie      (mode_q.ie),
        .flags_q (flags_q),
        .irq     (irq)
    );

endmodule

// File: rtl/tat_checker.sv
module tat_checker
    import tat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              irq,
    input logic              tick,
    input logic              restart,
    input logic              status_rd,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic [FLAG_N-1:0] flags_q,
    input logic [FLAG_N-1:0] ie
);

    // R3
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count_q == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_q == $past(count_q) + 1'b1));

    // R4
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(count_q));

    // R5
    alarm_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((alarm_q == ALARM_OFF) && !flags_q[FLAG_ALM]) |=> !flags_q[FLAG_ALM]);

    // R6
    inc_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> flags_q[FLAG_INC]);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !tick) |=> (flags_q == '0));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ie == '0) |-> !irq);

    // R9
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind tick_alarm_timer tat_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .tick      (tick),
    .restart   (restart),
    .status_rd (status_rd),
    .count_q   (count_q),
    .alarm_q   (alarm_q),
    .flags_q   (flags_q),
    .ie        (mode_q.ie)
);

// File: tb/tick_alarm_timer_bench.sv
`timescale 1ns/1ps
module tick_alarm_timer_bench;

    localparam logic [3:0] A_MODE   = 4'h0;
    localparam logic [3:0] A_ALARM  = 4'h4;
    localparam logic [3:0] A_VALUE  = 4'h8;
    localparam logic [3:0] A_STATUS = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tick_alarm_timer u_tick_alarm_timer (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic slow_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
        end
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(A_MODE, d);   check("R1 mode reset", d, 32'h0000_8000);
        check("R9 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
        bus_read(A_ALARM, d);  check("R1 alarm reset", d, 32'hFFFF_FFFF);
        bus_read(A_VALUE, d);  check("R1 value reset", d, 32'd0);
        bus_read(A_STATUS, d); check("R1 status reset", d, 32'd0);
        check("R1 irq reset", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        bus_write(A_MODE, 32'h0004_0003);
        slow_run(2); bus_read(A_VALUE, d); check("R2 before 3rd strobe", d, 32'd0);
        slow_run(1); bus_read(A_VALUE, d); check("R2 after 3 strobes", d, 32'd1);
        slow_run(6); bus_read(A_VALUE, d); check("R2 after 9 strobes", d, 32'd3);
        bus_read(A_MODE, d); check("R3 restart reads 0", d, 32'h0000_0003);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        slow_run(2);
        bus_write(A_MODE, 32'h0004_0003);
        bus_read(A_VALUE, d); check("R3 counter cleared", d, 32'd0);
        slow_run(2); bus_read(A_VALUE, d); check("R3 divider cleared", d, 32'd0);
        slow_run(1); bus_read(A_VALUE, d); check("R3 counts from zero", d, 32'd1);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        bus_write(A_VALUE, 32'hDEAD_0000);
        bus_read(A_VALUE, d); check("R4 value not loadable", d, 32'd1);
    endtask

    task automatic t_inc_flag;
        logic [31:0] d;
        bus_read(A_STATUS, d); check("R6 increment flag set", d, 32'd2);
        bus_read(A_STATUS, d); check("R7 cleared by read", d, 32'd0);
        slow_run(1); bus_read(A_STATUS, d); check("R6 no flag mid-period", d, 32'd0);
        slow_run(2); bus_read(A_STATUS, d); check("R6 flag on advance", d, 32'd2);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        bus_write(A_MODE, 32'h0002_0003);
        check("R8 irq low, flags clear", {31'b0, irq}, 32'd0);
        slow_run(3);
        check("R8 irq on enabled increment", {31'b0, irq}, 32'd1);
        bus_read(A_STATUS, d); check("R7 status before clear", d, 32'd2);
        check("R8 irq drops after clear", {31'b0, irq}, 32'd0);
        bus_write(A_MODE, 32'h0000_0003);
        slow_run(3);
        check("R8 masked flag no irq", {31'b0, irq}, 32'd0);
        bus_read(A_STATUS, d); check("R8 masked flag still in status", d, 32'd2);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        bus_write(A_MODE, 32'h0004_0003);
        bus_write(A_ALARM, 32'd2);
        bus_read(A_ALARM, d); check("R9 alarm register", d, 32'd2);
        bus_read(A_STATUS, d);
        slow_run(3); bus_read(A_STATUS, d); check("R5 no alarm before match", d, 32'd2);
        bus_write(A_MODE, 32'h0001_0003);
        slow_run(3);
        check("R8 alarm irq", {31'b0, irq}, 32'd1);
        bus_read(A_STATUS, d); check("R5 alarm at match", d, 32'd3);
        check("R8 alarm irq cleared", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        bus_read(A_STATUS, d);
        slow_run(2);
        @(negedge clk);
        slow_tick = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = A_STATUS;
        @(negedge clk);
        slow_tick = 1'b0; req_valid = 1'b0;
        d = rsp_rdata; check("R7 read sees pre-event flags", d, 32'd0);
        bus_read(A_STATUS, d); check("R7 same-cycle event kept", d, 32'd2);
        bus_read(A_VALUE, d); check("R2 count after collision", d, 32'd3);
    endtask

    task automatic t_alarm_off;
        logic [31:0] d;
        bus_write(A_ALARM, 32'hFFFF_FFFF);
        bus_write(A_MODE, 32'h0004_0001);
        bus_read(A_STATUS, d);
        slow_run(4); bus_read(A_STATUS, d); check("R5 disabled alarm silent", d, 32'd2);
    endtask

    task automatic t_div_full;
        logic [31:0] d;
        bus_write(A_MODE, 32'h0004_0000);
        bus_read(A_MODE, d); check("R2 ratio 0 stored", d, 32'd0);
        bus_read(A_STATUS, d);
        slow_run(65535);
        bus_read(A_VALUE, d);  check("R2 ratio 0 before 65536", d, 32'd0);
        bus_read(A_STATUS, d); check("R6 no flag before 65536", d, 32'd0);
        slow_run(1);
        bus_read(A_VALUE, d);  check("R2 ratio 0 at 65536", d, 32'd1);
        bus_read(A_STATUS, d); check("R6 flag at 65536", d, 32'd2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_restart();
        t_readonly();
        t_inc_flag();
        t_irq();
        t_alarm();
        t_collision();
        t_alarm_off();
        t_div_full();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule